// File: doc/BRIEF.md
# Multi-Format Stereo Serial Audio Receiver

This block turns a slave-mode stereo serial audio stream into parallel samples. It runs on a fast system clock and oversamples three asynchronous lines: the bit clock (`sck_i`), the word-select clock (`ws_i`) and the serial data (`sd_i`). The bit clock runs at 64 times the sample rate, so each channel occupies a half-frame of 32 bit slots. Data is sent MSB first in two's-complement form and is taken on the rising bit-clock edge.

A two-bit format code selects one of four framings. Each framing has its own word-select polarity and its own slot window. A separate force input overrides the code and selects the 20-bit I2S framing. Completed left and right words appear on two 20-bit outputs. A one-cycle strobe marks each frame once its right word lands, provided a left word arrived before it. Bit-clock and word-select edges are found after two-flop synchronizers. For this reason the system clock must run at least four times faster than the bit clock.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted and directly after its release, `left_o` and `right_o` are zero and `frame_valid_o` is low.
- R2: Format code 2'b00 (20-bit MSB-first, left-aligned) treats `ws_i` high as left. The MSB is taken on the first `sck_i` rise after a `ws_i` transition (slot 0), and the word fills slots 0 to 19.
- R3: Format code 2'b01 (20-bit I2S) treats `ws_i` low as left. The MSB sits in slot 1, one bit clock after the `ws_i` transition, and the word fills slots 1 to 20.
- R4: Format code 2'b10 (20-bit right-aligned) treats `ws_i` high as left. The word fills slots 12 to 31, with the LSB in slot 31.
- R5: Format code 2'b11 (16-bit right-aligned) treats `ws_i` high as left. The word fills slots 16 to 31. It is delivered in the upper 16 bits of the output with the four low bits zero.
- R6: With `i2s_force_i` high, the I2S framing of R3 applies whatever `fmt_sel_i` holds.
- R7: Bits in slots outside the active framing's window have no effect on the delivered words.
- R8: `frame_valid_o` pulses for exactly one system clock when a right word completes. It pulses only if a left word completed since the previous pulse.
- R9: The format in force is sampled at each `ws_i` transition. A change of `fmt_sel_i` or `i2s_force_i` in mid half-frame only takes effect at the next transition.
- R10: The slot count restarts at every `ws_i` transition. Before the first transition after reset, no bit is captured.
- R11: A delivered word changes only on the third system clock rising edge after the `sck_i` rise that carries its final bit. `frame_valid_o` rises on that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck_i | input | 1 | Serial bit clock, 64x sample rate, asynchronous |
| ws_i | input | 1 | Word-select (channel) clock, asynchronous |
| sd_i | input | 1 | Serial data, changes on the falling bit-clock edge |
| fmt_sel_i | input | 2 | Framing code (see R2 to R5) |
| i2s_force_i | input | 1 | High forces the I2S framing |
| left_o | output | WORD_W | Last completed left-channel word |
| right_o | output | WORD_W | Last completed right-channel word |
| frame_valid_o | output | 1 | One-cycle strobe when a stereo frame is complete |

## Verification
Each word and the strobe are due on the third system clock rising edge after the bit-clock rise that carries the final bit: two edges pass through the synchronizer and one passes through the edge-detect register. The bench changes its inputs only on falling system clock edges. It reads the words eight system clocks after the last bit-clock rise of a frame, which is past the due edge and before the next bit-clock fall. Strobes are counted on every falling system clock edge, so that a missing or doubled pulse shows up in the count taken at the same point.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;

  // Framing codes; the values are the external selection code.
  typedef enum logic [1:0] {
    FMT_MSB20 = 2'b00,
    FMT_I2S20 = 2'b01,
    FMT_LSB20 = 2'b10,
    FMT_LSB16 = 2'b11
  } rx_fmt_e;

endpackage

// File: rtl/arx_sync_bank.sv
// Multi-flop synchronizers for a bank of asynchronous lines; the first
// EDGE_LINES lines also get a delayed copy for edge detection.
module arx_sync_bank #(
  parameter int LINES      = 3,
  parameter int EDGE_LINES = 2,
  parameter int STAGES     = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [LINES-1:0]      async_i,
  output logic [LINES-1:0]      sync_o,
  output logic [EDGE_LINES-1:0] prev_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
      end else begin
        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
      end
    end

    assign sync_o[g] = chain_q[STAGES-1];

    if (g < EDGE_LINES) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prev_q <= 1'b0;
        end else begin
          prev_q <= chain_q[STAGES-1];
        end
      end
      assign prev_o[g] = prev_q;
    end
  end

endmodule

// File: rtl/arx_slot_ctrl.sv
// Slot counter, per-half-frame format latch and capture-window decode.
module arx_slot_ctrl
  import audio_rx_pkg::*;
#(
  parameter int SLOTS   = 32,
  parameter int WORD_W  = 20,
  parameter int SHORT_W = 16,
  parameter int CNT_W   = $clog2(SLOTS) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sck_lvl,
  input  logic             sck_prev,
  input  logic             ws_lvl,
  input  logic             ws_prev,
  input  logic [1:0]       fmt_sel_i,
  input  logic             i2s_force_i,
  output logic             sck_rise,
  output logic             ws_edge,
  output logic             bit_take,
  output logic             bit_last,
  output logic             is_right,
  output logic             is_short,
  output logic [CNT_W-1:0] slot_cnt,
  output rx_fmt_e          cur_fmt
);

  localparam logic [CNT_W-1:0] CNT_MAX    = '1;
  localparam logic [CNT_W-1:0] ONE        = CNT_W'(1);
  localparam logic [CNT_W-1:0] LO_MSB     = '0;
  localparam logic [CNT_W-1:0] LO_I2S     = ONE;
  localparam logic [CNT_W-1:0] LO_LSB20   = CNT_W'(SLOTS - WORD_W);
  localparam logic [CNT_W-1:0] LO_LSB16   = CNT_W'(SLOTS - SHORT_W);
  localparam logic [CNT_W-1:0] LEN_LONG   = CNT_W'(WORD_W);
  localparam logic [CNT_W-1:0] LEN_SHORT  = CNT_W'(SHORT_W);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  rx_fmt_e          fmt_q, fmt_d, eff_fmt;
  logic             right_q, right_d;
  logic [CNT_W-1:0] win_lo, win_len, win_end, win_last;
  logic             in_win;

  // edge detection on synchronized lines
  assign sck_rise = sck_lvl & ~sck_prev;
  assign ws_edge  = ws_lvl ^ ws_prev;
  assign eff_fmt  = i2s_force_i ? FMT_I2S20 : rx_fmt_e'(fmt_sel_i);

  // next-state logic
  always_comb begin
    cnt_d   = cnt_q;
    fmt_d   = fmt_q;
    right_d = right_q;
    if (ws_edge) begin
      cnt_d   = '0;
      fmt_d   = eff_fmt;
      right_d = (eff_fmt == FMT_I2S20) ? ws_lvl : ~ws_lvl;
    end else if (sck_rise && (cnt_q != CNT_MAX)) begin
      cnt_d = cnt_q + ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CNT_MAX;
      fmt_q   <= FMT_MSB20;
      right_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      fmt_q   <= fmt_d;
      right_q <= right_d;
    end
  end

  // capture window of the format in force
  always_comb begin
    unique case (fmt_q)
      FMT_MSB20: begin win_lo = LO_MSB;   win_len = LEN_LONG;  end
      FMT_I2S20: begin win_lo = LO_I2S;   win_len = LEN_LONG;  end
      FMT_LSB20: begin win_lo = LO_LSB20; win_len = LEN_LONG;  end
      default:   begin win_lo = LO_LSB16; win_len = LEN_SHORT; end
    endcase
    win_end  = win_lo + win_len;
    win_last = win_end - ONE;
    in_win   = (cnt_q >= win_lo) && (cnt_q < win_end);
  end

  assign bit_take = sck_rise & in_win & ~ws_edge;
  assign bit_last = bit_take & (cnt_q == win_last);
  assign is_right = right_q;
  assign is_short = (fmt_q == FMT_LSB16);
  assign slot_cnt = cnt_q;
  assign cur_fmt  = fmt_q;

endmodule

// File: rtl/arx_word_asm.sv
// Shift register and left/right word assembly with frame strobe.
module arx_word_asm #(
  parameter int WORD_W  = 20,
  parameter int SHORT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_take,
  input  logic              bit_last,
  input  logic              is_right,
  input  logic              is_short,
  input  logic              sd,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              frame_valid_o
);

  localparam int PAD_W = WORD_W - SHORT_W;

  logic [WORD_W-1:0] shreg_q, shreg_d, word;
  logic [WORD_W-1:0] left_q, right_q;
  logic              seen_q, seen_d;
  logic              valid_q, valid_d;
  logic              left_en, right_en;

  always_comb begin
    shreg_d  = bit_take ? {shreg_q[WORD_W-2:0], sd} : shreg_q;
    word     = is_short ? {shreg_d[SHORT_W-1:0], {PAD_W{1'b0}}} : shreg_d;
    left_en  = bit_last & ~is_right;
    right_en = bit_last &  is_right;
    valid_d  = right_en & seen_q;
    seen_d   = seen_q;
    if (left_en) begin
      seen_d = 1'b1;
    end else if (right_en) begin
      seen_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      seen_q  <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      seen_q  <= seen_d;
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (left_en) begin
      left_q <= word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      right_q <= '0;
    end else if (right_en) begin
      right_q <= word;
    end
  end

  assign left_o        = left_q;
  assign right_o       = right_q;
  assign frame_valid_o = valid_q;

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import audio_rx_pkg::*;
#(
  parameter int WORD_W      = 20,
  parameter int SHORT_W     = 16,
  parameter int SLOTS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_i,
  input  logic              ws_i,
  input  logic              sd_i,
  input  logic [1:0]        fmt_sel_i,
  input  logic              i2s_force_i,
  output logic [WORD_W-1:0] left_o,
  output logic [WORD_W-1:0] right_o,
  output logic              frame_valid_o
);

  localparam int CNT_W = $clog2(SLOTS) + 1;

  logic [2:0]       sync_lines;
  logic [1:0]       prev_lines;
  logic             sck_rise, ws_edge;
  logic             bit_take, bit_last, is_right, is_short;
  logic [CNT_W-1:0] slot_cnt;
  rx_fmt_e          cur_fmt;

  arx_sync_bank #(
    .LINES      (3),
    .EDGE_LINES (2),
    .STAGES     (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({sd_i, ws_i, sck_i}),
    .sync_o  (sync_lines),
    .prev_o  (prev_lines)
  );

  arx_slot_ctrl #(
    .SLOTS   (SLOTS),
    .WORD_W  (WORD_W),
    .SHORT_W (SHORT_W),
    .CNT_W   (CNT_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .sck_lvl     (sync_lines[0]),
    .sck_prev    (prev_lines[0]),
    .ws_lvl      (sync_lines[1]),
    .ws_prev     (prev_lines[1]),
    .fmt_sel_i   (fmt_sel_i),
    .i2s_force_i (i2s_force_i),
    .sck_rise    (sck_rise),
    .ws_edge     (ws_edge),
    .bit_take    (bit_take),
    .bit_last    (bit_last),
    .is_right    (is_right),
    .is_short    (is_short),
    .slot_cnt    (slot_cnt),
    .cur_fmt     (cur_fmt)
  );

  arx_word_asm #(
    .WORD_W  (WORD_W),
    .SHORT_W (SHORT_W)
  ) u_asm (
    .clk           (clk),
    .rst_n         (rst_n),
    .bit_take      (bit_take),
    .bit_last      (bit_last),
    .is_right      (is_right),
    .is_short      (is_short),
    .sd            (sync_lines[2]),
    .left_o        (left_o),
    .right_o       (right_o),
    .frame_valid_o (frame_valid_o)
  );

endmodule

// File: rtl/arx_checker.sv
module arx_checker #(
  parameter int WORD_W  = 20,
  parameter int SHORT_W = 16,
  parameter int CNT_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sck_rise,
  input logic              ws_edge,
  input logic [CNT_W-1:0]  slot_cnt,
  input logic [1:0]        cur_fmt,
  input logic [WORD_W-1:0] left_o,
  input logic [WORD_W-1:0] right_o,
  input logic              frame_valid_o
);

  localparam int PAD_W = WORD_W - SHORT_W;

  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |=> !frame_valid_o); // R8

  AST_STROBE_AFTER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid_o |-> $past(sck_rise)); // R11

  AST_LEFT_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (left_o != $past(left_o)) |-> $past(sck_rise)); // R11

  AST_RIGHT_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (right_o != $past(right_o)) |-> $past(sck_rise)); // R11

  AST_SHORT_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((left_o != $past(left_o)) && (cur_fmt == 2'b11)) |-> (left_o[PAD_W-1:0] == '0)); // R5

  AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !ws_edge |=> $stable(cur_fmt)); // R9

  AST_SLOT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ws_edge |=> (slot_cnt == '0)); // R10

endmodule

bind serial_audio_rx arx_checker #(
  .WORD_W  (WORD_W),
  .SHORT_W (SHORT_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sck_rise      (sck_rise),
  .ws_edge       (ws_edge),
  .slot_cnt      (slot_cnt),
  .cur_fmt       (cur_fmt),
  .left_o        (left_o),
  .right_o       (right_o),
  .frame_valid_o (frame_valid_o)
);

// File: tb/sim_serial_audio_rx.sv
`timescale 1ns/1ps
module sim_serial_audio_rx;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0;
  logic        ws = 1'b0;
  logic        sd = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic        i2s_force = 1'b0;
  logic [19:0] left_w, right_w;
  logic        frame_valid;

  int checks = 0;
  int failures = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  serial_audio_rx u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .sck_i         (sck),
    .ws_i          (ws),
    .sd_i          (sd),
    .fmt_sel_i     (fmt_sel),
    .i2s_force_i   (i2s_force),
    .left_o        (left_w),
    .right_o       (right_w),
    .frame_valid_o (frame_valid)
  );

  always @(negedge clk) if (rst_n && frame_valid) pulses++;

  task automatic chk(input string tag, input logic [19:0] act, input logic [19:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // window of a framing: first slot and word length
  function automatic void win(input int f, output int lo, output int n);
    case (f)
      0: begin lo = 0;  n = 20; end
      1: begin lo = 1;  n = 20; end
      2: begin lo = 12; n = 20; end
      default: begin lo = 16; n = 16; end
    endcase
  endfunction

  function automatic logic [19:0] expect_word(input int f, input logic [19:0] w);
    return (f == 3) ? {w[19:4], 4'h0} : w;
  endfunction

  function automatic string tag_of(input int f, input bit force_i);
    if (force_i) return "R6";
    case (f)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R5";
    endcase
  endfunction

  // one bit slot: data and ws change at the falling bit-clock edge
  task automatic drive_slot(input logic wsv, input logic b);
    @(negedge clk);
    sck = 1'b0; ws = wsv; sd = b;
    repeat (7) @(negedge clk);
    sck = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic send_half(input int f, input logic wsv, input logic [19:0] w,
                           input int sw_slot, input logic [1:0] sw_fmt);
    int lo, n;
    win(f, lo, n);
    for (int s = 0; s < 32; s++) begin
      logic b;
      if (s == sw_slot) fmt_sel = sw_fmt;
      if (s >= lo && s < lo + n) b = w[19 - (s - lo)];
      else b = ~s[0];  // filler in unused slots (R7)
      drive_slot(wsv, b);
    end
  endtask

  task automatic run_frame(input int fsel, input bit force_i, input logic [19:0] lw,
                           input logic [19:0] rw, input int mid);
    int eff, eff_r, p0;
    logic llvl;
    string tg;
    fmt_sel = fsel[1:0];
    i2s_force = force_i;
    eff = force_i ? 1 : fsel;
    llvl = (eff == 1) ? 1'b0 : 1'b1;
    if (ws == llvl) begin
      p0 = pulses;
      send_half(eff, ~llvl, 20'h0, -1, 2'b00);
      chk("R8 no strobe for right word without left", 20'(pulses), 20'(p0));
    end
    p0 = pulses;
    eff_r = (mid >= 0) ? mid : eff;
    send_half(eff, llvl, lw, (mid >= 0) ? 5 : -1, mid[1:0]);
    send_half(eff_r, ~llvl, rw, -1, 2'b00);
    tg = tag_of(eff, force_i);
    chk({tg, " R7 left word"}, left_w, expect_word(eff, lw));
    if (mid >= 0) chk("R9 right word after mid-half format change", right_w, expect_word(eff_r, rw));
    else chk({tg, " R7 right word"}, right_w, expect_word(eff_r, rw));
    chk("R8 one strobe per frame", 20'(pulses), 20'(p0 + 1));
  endtask

  function automatic logic [19:0] pat(input int k);
    case (k)
      0: return 20'h00000;
      1: return 20'hFFFFF;
      2: return 20'h80000;
      3: return 20'h7FFFF;
      default: return 20'(k * 246183) ^ 20'h5A5A5;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 left in reset", left_w, 20'h0);
    chk("R1 right in reset", right_w, 20'h0);
    chk("R1 strobe in reset", {19'h0, frame_valid}, 20'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 left after release", left_w, 20'h0);
    chk("R1 strobe after release", {19'h0, frame_valid}, 20'h0);

    // bits with no word-select transition yet are not captured
    for (int s = 0; s < 40; s++) drive_slot(1'b0, 1'b1);
    chk("R10 no capture before first ws edge (left)", left_w, 20'h0);
    chk("R10 no capture before first ws edge (right)", right_w, 20'h0);
    chk("R10 no strobe before first ws edge", 20'(pulses), 20'h0);

    // sweep of framing code, force input and data patterns
    for (int f = 0; f < 4; f++)
      for (int fo = 0; fo < 2; fo++)
        for (int k = 0; k < 6; k++) begin
          logic [19:0] lw, rw;
          lw = pat(k);
          rw = {lw[9:0], lw[19:10]} ^ 20'h0A0A0;
          run_frame(f, fo[0], lw, rw, -1);
        end

    // format changes inside a left half-frame (R9)
    run_frame(0, 1'b0, 20'hC3A51, 20'h1E2D3, 2);
    run_frame(2, 1'b0, 20'h6B7C8, 20'hF00F0, 3);
    run_frame(3, 1'b0, 20'h9ABCD, 20'h24680, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule